// File: doc/BRIEF.md
# MDIO Management Slave with Interrupt Register

This block answers clause-22 management frames arriving on an MDC/MDIO pair. It watches for a long run of ones followed by a start pattern, decodes a read or write opcode and a PHY address, and answers only when that address equals a 5-bit strap input. On a read it takes over the data line for the second turnaround bit and the sixteen data bits. On a write it stores the sixteen bits it receives. The bidirectional line is split into a receive input, a drive value and an output enable, which the pad ring combines into one pin.

Behind the frame decoder is a small register file. Addresses 0 to 6 are plain 16-bit storage. Address 0x1B is the interrupt register: the upper byte holds enables and the lower byte holds condition flags. Status-change pulses set the flags, and a read of the register clears them. Address 0x1F is a control word, and bit 9 of that word sets the polarity of the interrupt pin. MDC and MDIO are sampled with the block's own fast clock, so the management clock never clocks any flop.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only if its 5-bit PHY address equals `phy_addr`, and any strap value from 0 to 31 works. For a frame with another address, `mdio_oe` stays low and no register changes.
- R2: A frame is accepted only after at least 32 consecutive ones. Each field is sampled on an MDC rising edge, MSB first, in this order: start bits 0,1; opcode (10 = read, 01 = write); PHY address; register address; two turnaround bits; 16 data bits. A frame with only 31 preamble ones, or with opcode 00 or 11, is ignored.
- R3: On an accepted read, `mdio_oe` stays low through the first turnaround bit. After the MDC falling edge that follows that bit, the block drives 0. It then drives the 16 data bits MSB first, and each bit changes only after an MDC falling edge. It releases the line after the falling edge that follows the last bit.
- R4: Addresses 0 to 6 each hold a 16-bit value that resets to 0 and reads back the last value written.
- R5: A read of any address other than 0 to 6, 0x1B and 0x1F returns 0. A write to such an address changes nothing.
- R6: Register 0x1B reads as {enable[7:0], cond[7:0]}. A write sets the enable byte from data[15:8] and ignores data[7:0]. A one on `status_evt[i]` in any clock cycle sets cond[i], and cond[i] stays set until the register is read.
- R7: A read of 0x1B returns the flags as they stood when the register address was sampled, then clears them. A `status_evt` bit that is high in that same clock cycle stays set.
- R8: The interrupt is pending when any cond[i] and its enable[i] are both one. Register 0x1F is fully read/write storage, and its bit 9 sets the pin polarity: 1 makes `irq` high when pending, 0 (the reset value) makes `irq` low when pending.
- R9: After reset `mdio_oe` is low and `irq` is high, which is inactive with the default active-low polarity.
- R10: MDC and MDIO pass through a two-stage synchronizer. An MDC rising edge takes effect on the third `clk` rising edge after MDC goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the MDC rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Received level of the management data line |
| phy_addr | input | 5 | PHY address strap |
| status_evt | input | 8 | Status-change pulses, one per condition flag |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| irq | output | 1 | Interrupt pin, polarity set by 0x1F bit 9 |

## Verification
On every cycle the assertions check the following properties of the data line and the flags. The data line is released whenever no frame is in progress. It starts driving with a 0 and changes only after MDC falling edges. A flag never drops except through the clearing read, and an event always leaves its flag set. Address matching, preamble length, opcode rejection, readback of each address and the interrupt polarity need whole frames, so only the bench scenarios can show them. The same holds for an event that lands in the exact cycle of the clearing read. A behavioural model in the bench compares the interrupt pin and the line enable on every idle clock.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int          NSTD     = 7,
  parameter logic [4:0]  IRQ_ADDR = 5'h1B,
  parameter logic [4:0]  CTL_ADDR = 5'h1F,
  parameter int          POL_BIT  = 9,
  parameter int          PRE_LEN  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       mdio_i,
  input  logic [4:0] phy_addr,
  input  logic [7:0] status_evt,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       irq
);
  localparam int PW = $clog2(PRE_LEN + 1);

  typedef enum logic [1:0] {S_PRE, S_HDR, S_XFER} st_t;

  logic [2:0]    mdc_q;
  logic [1:0]    din_q;
  st_t           st;
  logic [PW-1:0] ones;
  logic [3:0]    hcnt;
  logic [11:0]   hdr;
  logic [4:0]    xcnt;
  logic          rd;
  logic [4:0]    ra;
  logic [15:0]   sh;
  logic [15:0]   std_q [NSTD];
  logic [7:0]    ien, icond;
  logic [15:0]   ctl;
  logic [15:0]   rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mdc_q <= '0;
      din_q <= '1;
    end else begin
      mdc_q <= {mdc_q[1:0], mdc};
      din_q <= {din_q[0], mdio_i};
    end

  wire rise   = mdc_q[1] & ~mdc_q[2];
  wire fall   = ~mdc_q[1] & mdc_q[2];
  wire bit_in = din_q[1];

  wire [12:0] hnext  = {hdr, bit_in};
  wire        h_done = rise && st == S_HDR && hcnt == 4'd12;
  wire        h_ok   = hnext[12] && (hnext[11:10] == 2'b10 || hnext[11:10] == 2'b01)
                       && hnext[9:5] == phy_addr;
  wire        clr    = h_done && h_ok && hnext[11:10] == 2'b10 && hnext[4:0] == IRQ_ADDR;
  wire        wr_go  = rise && st == S_XFER && !rd && xcnt == 5'd17;
  wire [15:0] wdata  = {sh[14:0], bit_in};

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSTD; i++)
      if (hnext[4:0] == i[4:0]) rdata = std_q[i];
    if (hnext[4:0] == IRQ_ADDR) rdata = {ien, icond};
    if (hnext[4:0] == CTL_ADDR) rdata = ctl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_PRE;
      ones    <= '0;
      hcnt    <= '0;
      hdr     <= '0;
      xcnt    <= '0;
      rd      <= 1'b0;
      ra      <= '0;
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (rise) begin
      case (st)
        S_PRE:
          if (bit_in) begin
            if (ones != PW'(PRE_LEN)) ones <= ones + 1'b1;
          end else begin
            if (ones == PW'(PRE_LEN)) begin
              st   <= S_HDR;
              hcnt <= '0;
            end
            ones <= '0;
          end
        S_HDR: begin
          hdr  <= hnext[11:0];
          hcnt <= hcnt + 1'b1;
          if (hcnt == 4'd12) begin
            if (h_ok) begin
              st   <= S_XFER;
              xcnt <= '0;
              rd   <= hnext[11:10] == 2'b10;
              ra   <= hnext[4:0];
              sh   <= rdata;
            end else begin
              st <= S_PRE;
            end
          end
        end
        default: begin
          xcnt <= xcnt + 1'b1;
          if (!rd) begin
            sh <= wdata;
            if (xcnt == 5'd17) st <= S_PRE;
          end
        end
      endcase
    end else if (fall && st == S_XFER && rd) begin
      if (xcnt == 5'd1) begin
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b0;
      end else if (xcnt >= 5'd2 && xcnt <= 5'd17) begin
        mdio_o <= sh[15];
        sh     <= {sh[14:0], 1'b0};
      end else if (xcnt == 5'd18) begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
        st      <= S_PRE;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NSTD; i++) std_q[i] <= '0;
      ien   <= '0;
      icond <= '0;
      ctl   <= '0;
    end else begin
      for (int i = 0; i < NSTD; i++)
        if (wr_go && ra == i[4:0]) std_q[i] <= wdata;
      if (wr_go && ra == IRQ_ADDR) ien <= wdata[15:8];
      if (wr_go && ra == CTL_ADDR) ctl <= wdata;
      icond <= clr ? status_evt : (icond | status_evt);
    end

  wire pend = |(ien & icond);
  assign irq = ctl[POL_BIT] ? pend : ~pend;

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       fall,
  input logic       clr,
  input logic [7:0] icond,
  input logic [7:0] status_evt,
  input logic       mdio_o,
  input logic       mdio_oe
);
  assert_release_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !mdio_oe);

  assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  assert_line_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_evt_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_evt != 8'd0) |=> ((icond & $past(status_evt)) == $past(status_evt)));

  assert_cond_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((icond & $past(icond)) == $past(icond)));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .fall(fall), .clr(clr),
  .icond(icond), .status_evt(status_evt), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
  logic       clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mdio_m = 1'b1;
  logic [4:0] strap = 5'd19;
  logic [7:0] evt = 8'd0;
  wire        mdio_o, mdio_oe, irq;
  wire        line = mdio_oe ? mdio_o : mdio_m;

  always #4 clk = ~clk;

  mdio_mgmt_slave u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line), .phy_addr(strap),
    .status_evt(evt), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit busy = 1'b1;

  logic [15:0] m_std [7];
  logic [7:0]  m_en = 0, m_cond = 0;
  logic [15:0] m_ctl = 0;

  function automatic logic [15:0] m_read(input int a);
    if (a < 7) return m_std[a];
    if (a == 27) return {m_en, m_cond};
    if (a == 31) return m_ctl;
    return 16'h0;
  endfunction

  function automatic void m_write(input int a, input logic [15:0] d);
    if (a < 7) m_std[a] = d;
    if (a == 27) m_en = d[15:8];
    if (a == 31) m_ctl = d;
  endfunction

  function automatic logic m_irq();
    logic p = |(m_en & m_cond);
    return m_ctl[9] ? p : !p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!busy && rst_n) begin
      chk(irq == m_irq(), "R8 irq per-clock", irq, m_irq());
      chk(!mdio_oe, "R3 idle release", mdio_oe, 0);
    end
  end

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bitw(input logic b);
    mdc = 1'b0; mdio_m = b; half();
    mdc = 1'b1; half();
  endtask

  task automatic head(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra, input int nreg);
    repeat (pre) bitw(1'b1);
    bitw(1'b0); bitw(1'b1); bitw(op[1]); bitw(op[0]);
    for (int i = 4; i >= 0; i--) bitw(phy[i]);
    for (int i = 4; i >= 5 - nreg; i--) bitw(ra[i]);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d,
                    input int pre = 32, input logic [1:0] op = 2'b01);
    busy = 1'b1;
    head(pre, op, phy, ra, 5);
    bitw(1'b1); bitw(1'b0);
    for (int i = 15; i >= 0; i--) bitw(d[i]);
    mdc = 1'b0; mdio_m = 1'b1; half();
  endtask

  task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input bit drive,
                    output logic [15:0] v, input logic [7:0] e = 8'd0);
    busy = 1'b1;
    head(32, 2'b10, phy, ra, 4);
    mdc = 1'b0; mdio_m = ra[0]; half();
    mdc = 1'b1;
    if (e != 0) begin
      // R10: address sampled on the third clk edge after MDC rises
      repeat (2) @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = 8'd0;
      repeat (5) @(negedge clk);
    end else half();
    mdc = 1'b0; mdio_m = 1'b1; half();
    chk(!mdio_oe, "R3 first turnaround released", mdio_oe, 0);
    mdc = 1'b1; half();
    mdc = 1'b0; half();
    if (drive) chk(mdio_oe && !mdio_o, "R3 second turnaround zero", {mdio_oe, mdio_o}, 2'b10);
    else chk(!mdio_oe, "R1 no drive on foreign address", mdio_oe, 0);
    mdc = 1'b1; half();
    for (int i = 15; i >= 0; i--) begin
      mdc = 1'b0; half();
      v[i] = line;
      chk(mdio_oe == drive, drive ? "R3 data driven" : "R1 data not driven", mdio_oe, drive);
      mdc = 1'b1; half();
    end
    mdc = 1'b0; half();
    chk(!mdio_oe, "R3 release after last bit", mdio_oe, 0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt = e;
    m_cond = m_cond | e;
    @(negedge clk);
    evt = 8'd0;
  endtask

  task automatic rd_chk(input logic [4:0] ra, input string req);
    logic [15:0] v, x;
    x = m_read(int'(ra));
    rd(strap, ra, 1'b1, v);
    chk(v === x, req, v, x);
    if (ra == 5'h1B) m_cond = 8'd0;
    settle();
  endtask

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 7; i++) m_std[i] = 16'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq === 1'b1, "R9 irq idle after reset", irq, 1);
    chk(mdio_oe === 1'b0, "R9 line released after reset", mdio_oe, 0);
    busy = 1'b0;

    rd_chk(5'd0, "R4 reset value");
    for (int i = 0; i < 7; i++) begin
      wr(strap, 5'(i), 16'h1357 * 16'(i + 1) ^ 16'hA0C3);
      m_write(i, 16'h1357 * 16'(i + 1) ^ 16'hA0C3);
      settle();
    end
    for (int i = 0; i < 7; i++) rd_chk(5'(i), "R4 readback");

    wr(strap, 5'h10, 16'hBEEF); settle();
    rd_chk(5'h10, "R5 unimplemented reads zero");
    rd_chk(5'h1E, "R5 unimplemented reads zero");
    rd_chk(5'd6, "R5 write elsewhere left storage alone");

    wr(5'd18, 5'd1, 16'hDEAD); settle();
    rd_chk(5'd1, "R1 foreign write ignored");
    rd(5'd18, 5'd1, 1'b0, v); settle();
    chk(v === 16'hFFFF, "R1 foreign read sees pull-up", v, 16'hFFFF);

    strap = 5'd0;
    wr(strap, 5'd2, 16'h0F0F); m_write(2, 16'h0F0F); settle();
    rd_chk(5'd2, "R1 strap 0");
    strap = 5'd31;
    wr(strap, 5'd2, 16'hF00D); m_write(2, 16'hF00D); settle();
    rd_chk(5'd2, "R1 strap 31");

    wr(strap, 5'd3, 16'h1111, 31); settle();
    rd_chk(5'd3, "R2 short preamble ignored");
    wr(strap, 5'd3, 16'h2222, 32, 2'b11); settle();
    rd_chk(5'd3, "R2 opcode 11 ignored");
    wr(strap, 5'd3, 16'h3333, 32, 2'b00); settle();
    rd_chk(5'd3, "R2 opcode 00 ignored");

    wr(strap, 5'h1B, 16'hA5FF); m_write(27, 16'hA5FF); settle();
    rd_chk(5'h1B, "R6 low byte not writable");
    pulse(8'h01);
    repeat (2) @(negedge clk);
    chk(irq === 1'b0, "R8 active-low pending", irq, 0);
    pulse(8'h02);
    rd_chk(5'h1B, "R7 read returns flags");
    rd_chk(5'h1B, "R7 flags cleared by read");
    chk(irq === 1'b1, "R8 irq idle after clear", irq, 1);

    wr(strap, 5'h1F, 16'h0200); m_write(31, 16'h0200); settle();
    chk(irq === 1'b0, "R8 active-high idle", irq, 0);
    rd_chk(5'h1F, "R8 control readback");
    pulse(8'h04);
    repeat (2) @(negedge clk);
    chk(irq === 1'b1, "R8 active-high pending", irq, 1);

    begin
      logic [15:0] x;
      x = m_read(27);
      rd(strap, 5'h1B, 1'b1, v, 8'h20);
      chk(v === x, "R10 R7 snapshot at address sample", v, x);
      m_cond = 8'h20;
      settle();
    end
    rd_chk(5'h1B, "R7 event in clearing cycle kept");

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule